// File: doc/BRIEF.md
# Prioritized Reference Clock Selector

This block chooses which of six candidate reference clocks drives one digital PLL. Upstream monitors deliver two synchronous "good" flags per input: one for activity and one for frequency offset. Four loss-of-signal pins can each be steered onto any input to knock it out. An input that passes every check and has a nonzero priority is a candidate for automatic selection.

Software fills a priority table and sets three controls: force an index, allow revertive switching, and route the loss-of-signal pins. The block registers the chosen index. It raises a flag while no candidate exists. It gives a one-cycle pulse whenever the index moves, so that a downstream mode controller can start a relock or holdover sequence.

Top module: `ref_selector`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `sel_idx` = 0, `none_ok` = 1 and `sel_chg` = 0.
- R2: An input is usable only when its bit in `act_ok` and its bit in `freq_ok` are both 1 and no enabled, asserted loss-of-signal pin is mapped to it.
- R3: Loss pin k has a 3-bit target field at `los_map[3k+2:3k]` and an enable at `los_en[k]`. When the pin is high and enabled, it disqualifies the target input. A disabled pin, or a pin whose target is 6 or 7, has no effect.
- R4: Input i has a 4-bit priority at `prio_tbl[4i+3:4i]`. The value 0 excludes the input from automatic choice. Among candidates the smallest nonzero value wins, and equal values go to the lowest index.
- R5: When `force_en` = 1 and `force_idx` < 6, `sel_idx` takes `force_idx` at the next edge, whatever the qualification of that input.
- R6: When `force_en` = 1 and `force_idx` is 6 or 7, `sel_idx` keeps its value. `sel_idx` never exceeds 5.
- R7: In automatic mode, when the current input is no longer a candidate and some candidate exists, the best candidate is selected at the next edge.
- R8: With `revert_en` = 1 in automatic mode, a candidate whose priority value is strictly smaller than that of the current input causes a switch to the best candidate.
- R9: With `revert_en` = 0 in automatic mode, the current input is kept for as long as it remains a candidate.
- R10: `none_ok` is 1 exactly when, at the previous edge, no input was a candidate. In automatic mode with no candidate, `sel_idx` holds.
- R11: `sel_chg` is 1 for exactly the cycles in which `sel_idx` differs from its value one cycle earlier.
- R12: Every output is registered and reflects the inputs present at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_ok | input | 6 | Activity monitor good flag per input |
| freq_ok | input | 6 | Frequency monitor good flag per input |
| los_pin | input | 4 | Loss-of-signal pins, active high |
| los_en | input | 4 | Enable per loss pin |
| los_map | input | 12 | Target input index per loss pin, 3 bits each |
| prio_tbl | input | 24 | Priority per input, 4 bits each, 0 = excluded |
| force_en | input | 1 | Forced selection enable |
| force_idx | input | 3 | Forced input index |
| revert_en | input | 1 | Revertive switching enable |
| sel_idx | output | 3 | Selected input index |
| none_ok | output | 1 | No candidate input available |
| sel_chg | output | 1 | One-cycle pulse on index change |

## Verification
The bound assertions check several rules on every cycle:
- a forced index is followed;
- the index is held in non-revertive mode while the current input stays a candidate;
- the index is held, with the flag raised, when no candidate exists;
- a disqualified current input always causes a switch;
- the change pulse matches an index movement;
- the index stays in range.

Other behaviours are shown only by the directed scenarios. These are the priority ordering and its tie rule, the effect of each loss-pin field and enable, the choice of target on a revertive switch, and the reset values.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;

    localparam int DEF_NUM_IN  = 6;
    localparam int DEF_NUM_LOS = 4;
    localparam int DEF_PRIO_W  = 4;

    // Kind of move the decision stage takes in one cycle
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_FORCE  = 2'd1,
        ACT_FAIL   = 2'd2,
        ACT_REVERT = 2'd3
    } sel_act_e;

endpackage

// File: rtl/ref_qualify.sv
module ref_qualify #(
    parameter int NUM_IN  = ref_sel_pkg::DEF_NUM_IN,
    parameter int NUM_LOS = ref_sel_pkg::DEF_NUM_LOS,
    parameter int IDX_W   = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0]        act_ok,
    input  logic [NUM_IN-1:0]        freq_ok,
    input  logic [NUM_LOS-1:0]       los_pin,
    input  logic [NUM_LOS-1:0]       los_en,
    input  logic [NUM_LOS*IDX_W-1:0] los_map,
    output logic [NUM_IN-1:0]        usable
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic los_hit;
        always_comb begin
            los_hit = 1'b0;
            for (int k = 0; k < NUM_LOS; k++) begin
                if (los_en[k] && los_pin[k] &&
                    los_map[k*IDX_W +: IDX_W] == IDX_W'(i))
                    los_hit = 1'b1;
            end
        end
        assign usable[i] = act_ok[i] & freq_ok[i] & ~los_hit;
    end

endmodule

// File: rtl/ref_rank.sv
module ref_rank #(
    parameter int NUM_IN = ref_sel_pkg::DEF_NUM_IN,
    parameter int PRIO_W = ref_sel_pkg::DEF_PRIO_W,
    parameter int IDX_W  = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0]        usable,
    input  logic [NUM_IN*PRIO_W-1:0] prio_tbl,
    output logic [NUM_IN-1:0]        cand,
    output logic                     any_cand,
    output logic [IDX_W-1:0]         best_idx,
    output logic [PRIO_W-1:0]        best_prio
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_cand
        assign cand[i] = usable[i] & (|prio_tbl[i*PRIO_W +: PRIO_W]);
    end

    // Scan from index 0 upward; strict compare keeps the lowest index on ties
    always_comb begin
        any_cand  = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < NUM_IN; i++) begin
            if (cand[i] && (!any_cand || prio_tbl[i*PRIO_W +: PRIO_W] < best_prio)) begin
                any_cand  = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_tbl[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/ref_decide.sv
module ref_decide
    import ref_sel_pkg::*;
#(
    parameter int NUM_IN = DEF_NUM_IN,
    parameter int PRIO_W = DEF_PRIO_W,
    parameter int IDX_W  = $clog2(NUM_IN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     force_en,
    input  logic [IDX_W-1:0]         force_idx,
    input  logic                     revert_en,
    input  logic [NUM_IN*PRIO_W-1:0] prio_tbl,
    input  logic [NUM_IN-1:0]        cand,
    input  logic                     any_cand,
    input  logic [IDX_W-1:0]         best_idx,
    input  logic [PRIO_W-1:0]        best_prio,
    output logic [IDX_W-1:0]         sel_idx,
    output logic                     none_ok,
    output logic                     sel_chg
);

    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(NUM_IN);

    sel_act_e           act;
    logic [IDX_W-1:0]   nxt_idx;
    logic [PRIO_W-1:0]  cur_prio;
    logic               cur_cand;
    logic               force_legal;

    assign cur_prio    = prio_tbl[sel_idx*PRIO_W +: PRIO_W];
    assign cur_cand    = cand[sel_idx];
    assign force_legal = {1'b0, force_idx} < IDX_LIMIT;

    always_comb begin
        act     = ACT_HOLD;
        nxt_idx = sel_idx;
        if (force_en) begin
            if (force_legal) begin
                act     = ACT_FORCE;
                nxt_idx = force_idx;
            end
        end else if (any_cand) begin
            if (!cur_cand) begin
                act     = ACT_FAIL;
                nxt_idx = best_idx;
            end else if (revert_en && best_prio < cur_prio) begin
                act     = ACT_REVERT;
                nxt_idx = best_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx <= '0;
            none_ok <= 1'b1;
            sel_chg <= 1'b0;
        end else begin
            sel_idx <= nxt_idx;
            none_ok <= !any_cand;
            sel_chg <= (act != ACT_HOLD) && (nxt_idx != sel_idx);
        end
    end

endmodule

// File: rtl/ref_selector.sv
module ref_selector #(
    parameter  int NUM_IN  = ref_sel_pkg::DEF_NUM_IN,
    parameter  int NUM_LOS = ref_sel_pkg::DEF_NUM_LOS,
    parameter  int PRIO_W  = ref_sel_pkg::DEF_PRIO_W,
    localparam int IDX_W   = $clog2(NUM_IN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IN-1:0]        act_ok,
    input  logic [NUM_IN-1:0]        freq_ok,
    input  logic [NUM_LOS-1:0]       los_pin,
    input  logic [NUM_LOS-1:0]       los_en,
    input  logic [NUM_LOS*IDX_W-1:0] los_map,
    input  logic [NUM_IN*PRIO_W-1:0] prio_tbl,
    input  logic                     force_en,
    input  logic [IDX_W-1:0]         force_idx,
    input  logic                     revert_en,
    output logic [IDX_W-1:0]         sel_idx,
    output logic                     none_ok,
    output logic                     sel_chg
);

    logic [NUM_IN-1:0] usable_vec;
    logic [NUM_IN-1:0] cand_vec;
    logic              any_cand;
    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_prio;

    ref_qualify #(.NUM_IN(NUM_IN), .NUM_LOS(NUM_LOS), .IDX_W(IDX_W)) u_qual (
        .act_ok  (act_ok),
        .freq_ok (freq_ok),
        .los_pin (los_pin),
        .los_en  (los_en),
        .los_map (los_map),
        .usable  (usable_vec)
    );

    ref_rank #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_rank (
        .usable    (usable_vec),
        .prio_tbl  (prio_tbl),
        .cand      (cand_vec),
        .any_cand  (any_cand),
        .best_idx  (best_idx),
        .best_prio (best_prio)
    );

    ref_decide #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .force_en  (force_en),
        .force_idx (force_idx),
        .revert_en (revert_en),
        .prio_tbl  (prio_tbl),
        .cand      (cand_vec),
        .any_cand  (any_cand),
        .best_idx  (best_idx),
        .best_prio (best_prio),
        .sel_idx   (sel_idx),
        .none_ok   (none_ok),
        .sel_chg   (sel_chg)
    );

endmodule

// File: rtl/ref_selector_chk.sv
module ref_selector_chk #(
    parameter int NUM_IN = 6,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              force_en,
    input logic [IDX_W-1:0]  force_idx,
    input logic              revert_en,
    input logic [NUM_IN-1:0] cand,
    input logic [IDX_W-1:0]  sel_idx,
    input logic              none_ok,
    input logic              sel_chg
);

    localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(NUM_IN);

    p_idx_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        {1'b0, sel_idx} < IDX_LIMIT);

    p_chg_tracks_r11: assert property (@(posedge clk) disable iff (rst)
        sel_chg == (sel_idx != $past(sel_idx)));

    p_force_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (force_en && ({1'b0, force_idx} < IDX_LIMIT)) |=> sel_idx == $past(force_idx));

    p_nonrev_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (!force_en && !revert_en && cand[sel_idx]) |=> $stable(sel_idx));

    p_none_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!force_en && cand == '0) |=> (none_ok && $stable(sel_idx)));

    p_disq_switch_r7: assert property (@(posedge clk) disable iff (rst)
        (!force_en && cand != '0 && !cand[sel_idx]) |=> sel_chg);

endmodule

bind ref_selector ref_selector_chk #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .force_en  (force_en),
    .force_idx (force_idx),
    .revert_en (revert_en),
    .cand      (cand_vec),
    .sel_idx   (sel_idx),
    .none_ok   (none_ok),
    .sel_chg   (sel_chg)
);

// File: tb/ref_selector_test.sv
module ref_selector_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  act_ok;
    logic [5:0]  freq_ok;
    logic [3:0]  los_pin;
    logic [3:0]  los_en;
    logic [11:0] los_map;
    logic [23:0] prio_tbl;
    logic        force_en;
    logic [2:0]  force_idx;
    logic        revert_en;
    logic [2:0]  sel_idx;
    logic        none_ok;
    logic        sel_chg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_selector uut (
        .clk(clk), .rst(rst), .act_ok(act_ok), .freq_ok(freq_ok),
        .los_pin(los_pin), .los_en(los_en), .los_map(los_map),
        .prio_tbl(prio_tbl), .force_en(force_en), .force_idx(force_idx),
        .revert_en(revert_en), .sel_idx(sel_idx), .none_ok(none_ok),
        .sel_chg(sel_chg)
    );

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic expect_out(string req, int idx, int none, int chg);
        chk({req, " sel_idx"}, int'(sel_idx), idx);
        chk({req, " none_ok"}, int'(none_ok), none);
        chk({req, " sel_chg"}, int'(sel_chg), chg);
    endtask

    task automatic set_prio(int i, int v);
        prio_tbl[i*4 +: 4] = 4'(v);
    endtask

    task automatic map_los(int k, int target, bit en, bit level);
        los_map[k*3 +: 3] = 3'(target);
        los_en[k]  = en;
        los_pin[k] = level;
    endtask

    task automatic defaults();
        act_ok = '1; freq_ok = '1;
        los_pin = '0; los_en = '0; los_map = '0;
        for (int i = 0; i < 6; i++) set_prio(i, i + 1);
        force_en = 1'b0; force_idx = '0; revert_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 0, 1, 0);
        rst = 1'b0;
        step();
        expect_out("R12 first edge", 0, 0, 0);
    endtask

    task automatic t_disqualify();
        act_ok[0] = 1'b0; step();
        expect_out("R2 R7 activity loss", 1, 0, 1);
        step();
        expect_out("R11 pulse ends", 1, 0, 0);
        freq_ok[1] = 1'b0; step();
        expect_out("R2 freq loss", 2, 0, 1);
    endtask

    task automatic t_nonrevert();
        act_ok = '1; freq_ok = '1; step();
        expect_out("R9 keep current", 2, 0, 0);
        for (int n = 0; n < 3; n++) begin
            step();
            expect_out("R9 keep held", 2, 0, 0);
        end
    endtask

    task automatic t_revert();
        revert_en = 1'b1; step();
        expect_out("R8 revert to best", 0, 0, 1);
        for (int i = 0; i < 6; i++) set_prio(i, 5);
        set_prio(0, 0); step();
        expect_out("R4 zero excludes, tie to lowest", 1, 0, 1);
        set_prio(3, 2); step();
        expect_out("R8 higher priority appears", 3, 0, 1);
        set_prio(2, 2); step();
        expect_out("R4 equal priority no switch", 3, 0, 0);
    endtask

    task automatic t_los();
        defaults(); revert_en = 1'b1; step();
        expect_out("R8 back to input 0", 0, 0, 1);
        map_los(2, 0, 1'b1, 1'b1); step();
        expect_out("R3 mapped pin disqualifies", 1, 0, 1);
        los_en[2] = 1'b0; step();
        expect_out("R3 disabled pin released", 0, 0, 1);
        map_los(1, 7, 1'b1, 1'b1);
        map_los(0, 0, 1'b0, 1'b1); step();
        expect_out("R3 out-of-range or disabled pin ignored", 0, 0, 0);
        map_los(3, 0, 1'b1, 1'b1); step();
        expect_out("R3 pin 3 field", 1, 0, 1);
        defaults(); step();
        expect_out("R9 after restore", 1, 0, 0);
    endtask

    task automatic t_force();
        force_en = 1'b1; force_idx = 3'd4; act_ok[4] = 1'b0; step();
        expect_out("R5 forced unqualified input", 4, 0, 1);
        force_idx = 3'd6; step();
        expect_out("R6 index 6 holds", 4, 0, 0);
        force_idx = 3'd7; step();
        expect_out("R6 index 7 holds", 4, 0, 0);
        force_en = 1'b0; step();
        expect_out("R7 leave force on bad input", 0, 0, 1);
    endtask

    task automatic t_none();
        act_ok = '0; step();
        expect_out("R10 nothing qualified", 0, 1, 0);
        act_ok = 6'b100000; step();
        expect_out("R10 R7 single input back", 5, 0, 1);
        act_ok = '1;
        for (int i = 0; i < 6; i++) set_prio(i, 0);
        step();
        expect_out("R10 all priorities zero", 5, 1, 0);
        force_en = 1'b1; force_idx = 3'd2; step();
        expect_out("R10 R5 force while none", 2, 1, 1);
    endtask

    initial begin
        defaults();
        rst = 1'b1;
        repeat (3) step();
        t_reset();
        t_disqualify();
        t_nonrevert();
        t_revert();
        t_los();
        t_force();
        t_none();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule